// File: doc/BRIEF.md
# Banked EPROM Read Sequencer

This block turns a single-cycle host read request into a timed read cycle on a group of parallel EPROM banks that share one address bus, one data bus and one output-enable line. The upper host address bits pick the bank. Only that bank's active-low chip enable is pulled low. Every other bank stays deselected, in its low-power standby. The shared active-low output enable falls in the same clock cycle as the chip enable and rises with it, so the common data bus is driven only while a read is in flight.

The access time and the output float time come from a speed-grade parameter, and the clock period is a parameter in picoseconds. Both times are rounded up to whole clock cycles when the design is elaborated. After the access time has elapsed, the byte on the data bus is registered and a one-cycle done pulse is issued. When consecutive reads target different banks, the next bank is not enabled until the previous bank's outputs have had their full float time. This keeps two devices from ever driving the bus at once. Consecutive reads to the same bank carry no such penalty.

Top module: `rombank_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every chip enable is high, the output enable is high and rd_done is low.
- R2: An accepted read for host address A drives the chip enable of bank A[HOST_W-1:BANK_ADDR_W] low and all others high, and drives mem_addr = A[BANK_ADDR_W-1:0]. At most one chip enable is ever low, and the address and enables stay constant for the whole access.
- R3: mem_oe_n is low exactly in the cycles in which some chip enable is low. It falls and rises in the same cycles as that enable.
- R4: An access holds its chip enable low for ACC_CYC cycles, where ACC_CYC = ceil(tACC / CLK_PS). tACC is 200, 250 or 300 ns for SPEED_GRADE 0, 1 or 2. With an idle controller and no float wait, the enables fall on the clock edge that samples rd_req, and rd_done rises ACC_CYC edges later.
- R5: The data bus is sampled on the edge that ends the access. It appears on rd_data with rd_done high for exactly one cycle, and rd_data then holds until the next done pulse.
- R6: When a read goes to a different bank than the previous access, its chip enable falls no fewer than FLT_CYC = ceil(tDF / CLK_PS) edges after the previous enables rose. tDF is 50, 60 or 105 ns for grades 0, 1 and 2. A read to the same bank, or one issued after that many edges, starts on the edge that samples rd_req.
- R7: rd_req is ignored while an access is in progress or waiting out a float gap. Such a request produces no done pulse and does not change the address or data of the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Host read request, sampled when the controller is idle |
| rd_addr | input | HOST_W | Host address: bank number in the upper bits, word address in the lower BANK_ADDR_W bits |
| rd_data | output | DATA_W | Registered read data |
| rd_done | output | 1 | One-cycle pulse: rd_data holds the requested word |
| mem_ce_n | output | NBANK | Per-bank active-low chip enable |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_addr | output | BANK_ADDR_W | Shared word address to the banks |
| mem_dq | input | DATA_W | Shared data bus from the banks |

## Verification
The assertions assume that reset is held through the first clock edge and that rd_req is always either 0 or 1. They also assume that CLK_PS matches the real clock, because the cycle counts in the gap and access-length properties are only as true as that parameter. The bench clock is 8 ns and the bench passes CLK_PS = 8000. It drives every request from the falling edge and holds it for one cycle. Its random reads cover all banks and idle spacings both shorter and longer than the float count, and a directed case raises rd_req in the middle of an access.

// File: rtl/rombank_pkg.sv
`timescale 1ns/1ps
package rombank_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_ACC  = 2'd2
  } rd_state_e;

  // access time from stable address / chip enable, in ns, per speed grade
  function automatic int unsigned grade_acc_ns(input int unsigned grade);
    case (grade)
      0:       return 200;
      1:       return 250;
      default: return 300;
    endcase
  endfunction

  // worst-case output float time after enable release, in ns, per grade
  function automatic int unsigned grade_float_ns(input int unsigned grade);
    case (grade)
      0:       return 50;
      1:       return 60;
      default: return 105;
    endcase
  endfunction

  // round a time in ns up to whole clock cycles, at least one
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/rombank_bank_dec.sv
`timescale 1ns/1ps
module rombank_bank_dec #(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0] bank,
  output logic [NBANK-1:0]  sel
);
  for (genvar i = 0; i < NBANK; i++) begin : g_sel
    assign sel[i] = (bank == BANK_W'(i));
  end
endmodule

// File: rtl/rombank_wait_ctr.sv
`timescale 1ns/1ps
module rombank_wait_ctr #(
  parameter int ACC_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(ACC_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (clr)           cnt <= CW'(1);
    else if (run && !last)  cnt <= cnt + CW'(1);
  end

  assign last = (cnt == CW'(ACC_CYC));
endmodule

// File: rtl/rombank_float_tmr.sv
`timescale 1ns/1ps
module rombank_float_tmr #(
  parameter int FLT_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int FW = $clog2(FLT_CYC + 1);

  logic [FW-1:0] cnt;

  // loaded with FLT_CYC-1 so that busy drops on the edge FLT_CYC after release
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= FW'(FLT_CYC - 1);
    else if (cnt != '0)    cnt <= cnt - FW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rombank_rd_ctrl.sv
`timescale 1ns/1ps
module rombank_rd_ctrl #(
  parameter int NBANK       = 4,
  parameter int BANK_ADDR_W = 13,
  parameter int DATA_W      = 8,
  parameter int CLK_PS      = 8000,
  parameter int SPEED_GRADE = 0,
  localparam int BANK_W     = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int HOST_W     = BANK_W + BANK_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_req,
  input  logic [HOST_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_done,
  output logic [NBANK-1:0]       mem_ce_n,
  output logic                   mem_oe_n,
  output logic [BANK_ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]      mem_dq
);
  import rombank_pkg::*;

  localparam int ACC_CYC = ns_to_cycles(grade_acc_ns(SPEED_GRADE), CLK_PS);
  localparam int FLT_CYC = ns_to_cycles(grade_float_ns(SPEED_GRADE), CLK_PS);

  rd_state_e         state;
  logic [HOST_W-1:0] pend_addr;
  logic [BANK_W-1:0] last_bank;
  logic [BANK_W-1:0] go_bank;
  logic [NBANK-1:0]  go_sel;
  logic [HOST_W-1:0] go_addr;
  logic              start;
  logic              finish;
  logic              acc_last;
  logic              flt_busy;
  logic              req_blocked;

  // the address a starting access uses: fresh from the host or held over a gap
  assign go_addr     = (state == ST_HOLD) ? pend_addr : rd_addr;
  assign go_bank     = go_addr[HOST_W-1 -: BANK_W];
  assign req_blocked = flt_busy && (rd_addr[HOST_W-1 -: BANK_W] != last_bank);

  always_comb begin
    start = 1'b0;
    case (state)
      ST_IDLE: start = rd_req && !req_blocked;
      ST_HOLD: start = !flt_busy;
      default: start = 1'b0;
    endcase
  end

  assign finish = (state == ST_ACC) && acc_last;

  rombank_bank_dec #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
    .bank (go_bank),
    .sel  (go_sel)
  );

  rombank_wait_ctr #(.ACC_CYC(ACC_CYC)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .run  (state == ST_ACC),
    .last (acc_last)
  );

  rombank_float_tmr #(.FLT_CYC(FLT_CYC)) u_float (
    .clk  (clk),
    .rst  (rst),
    .load (finish),
    .busy (flt_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend_addr <= '0;
      last_bank <= '0;
      mem_ce_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
      rd_data   <= '0;
      rd_done   <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (state == ST_IDLE && rd_req && req_blocked) begin
        pend_addr <= rd_addr;
        state     <= ST_HOLD;
      end
      if (start) begin
        mem_addr  <= go_addr[BANK_ADDR_W-1:0];
        mem_ce_n  <= ~go_sel;
        mem_oe_n  <= 1'b0;
        last_bank <= go_bank;
        state     <= ST_ACC;
      end
      if (finish) begin
        rd_data  <= mem_dq;
        rd_done  <= 1'b1;
        mem_ce_n <= '1;
        mem_oe_n <= 1'b1;
        state    <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/rombank_rd_ctrl_chk.sv
`timescale 1ns/1ps
module rombank_rd_ctrl_chk #(
  parameter int NBANK       = 4,
  parameter int BANK_ADDR_W = 13,
  parameter int ACC_CYC     = 25,
  parameter int FLT_CYC     = 7
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NBANK-1:0]       mem_ce_n,
  input logic                   mem_oe_n,
  input logic [BANK_ADDR_W-1:0] mem_addr,
  input logic                   rd_done
);
  localparam int LW = $clog2(ACC_CYC + 2);
  localparam int GW = $clog2(FLT_CYC + 1);

  logic [LW-1:0]    low_cnt;
  logic [GW-1:0]    gap_cnt;
  logic [NBANK-1:0] last_act;
  logic             have_prev;
  logic             any_low;

  assign any_low = !(&mem_ce_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      gap_cnt   <= '0;
      last_act  <= '1;
      have_prev <= 1'b0;
    end else begin
      if (any_low) begin
        low_cnt   <= (low_cnt == LW'(ACC_CYC + 1)) ? low_cnt : low_cnt + LW'(1);
        gap_cnt   <= '0;
        last_act  <= mem_ce_n;
        have_prev <= 1'b1;
      end else begin
        low_cnt <= '0;
        gap_cnt <= (gap_cnt == GW'(FLT_CYC)) ? gap_cnt : gap_cnt + GW'(1);
      end
    end
  end

  // R2: never more than one bank selected
  assert_one_bank_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n));

  // R2: address and selection stable across an access
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && !$past(mem_oe_n)) |-> ($stable(mem_addr) && $stable(mem_ce_n)));

  // R3: shared output enable tracks the selected bank's enable
  assert_oe_follows_ce_R3: assert property (@(posedge clk) disable iff (rst)
    mem_oe_n == !any_low);

  // R4: an access lasts exactly the rounded access time
  assert_access_len_R4: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (low_cnt == LW'(ACC_CYC)) && !any_low);

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  // R6: a different bank is enabled only after the float gap has elapsed
  assert_float_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (any_low && (&$past(mem_ce_n)) && have_prev && (mem_ce_n != last_act))
      |-> (gap_cnt == GW'(FLT_CYC)));

endmodule

bind rombank_rd_ctrl rombank_rd_ctrl_chk #(
  .NBANK       (NBANK),
  .BANK_ADDR_W (BANK_ADDR_W),
  .ACC_CYC     (ACC_CYC),
  .FLT_CYC     (FLT_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_addr (mem_addr),
  .rd_done  (rd_done)
);

// File: tb/rombank_rd_ctrl_bench.sv
`timescale 1ns/1ps
module rombank_rd_ctrl_bench;
  localparam int NB     = 4;
  localparam int AW     = 13;
  localparam int DW     = 8;
  localparam int BW     = 2;
  localparam int HW     = BW + AW;
  localparam int CLK_PS = 8000;
  localparam int GRADE  = 0;

  // expected counts from the requirement tables: 200 ns and 50 ns at 8 ns
  function automatic int ceil_cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  localparam int E_ACC = (GRADE == 0) ? 200 : (GRADE == 1) ? 250 : 300;
  localparam int E_FLT = (GRADE == 0) ? 50  : (GRADE == 1) ? 60  : 105;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [HW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_done;
  logic [NB-1:0] mem_ce_n;
  logic          mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq;

  int acc_c;
  int flt_c;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rombank_rd_ctrl #(
    .NBANK(NB), .BANK_ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .SPEED_GRADE(GRADE)
  ) u_rombank_rd_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_done(rd_done), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  // contents of the banks
  function automatic logic [DW-1:0] pat(input int b, input int a);
    return DW'((a * 7) ^ (a >> 5) ^ (b * 91) ^ 60);
  endfunction

  // bank model: valid data only after the access time with enables held low
  int mdl_cnt = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (&mem_ce_n) mdl_cnt <= 0;
    else           mdl_cnt <= mdl_cnt + 1;
  end

  function automatic int sel_bank(input logic [NB-1:0] ce);
    for (int i = 0; i < NB; i++) if (!ce[i]) return i;
    return -1;
  endfunction

  always_comb begin
    if (!(&mem_ce_n) && !mem_oe_n && mdl_cnt >= acc_c - 1)
      mem_dq = pat(sel_bank(mem_ce_n), int'(mem_addr));
    else
      mem_dq = ~pat(sel_bank(mem_ce_n), int'(mem_addr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor of bank selection, shared enable and float gaps
  logic [HW-1:0] cur_addr = '0;
  logic [NB-1:0] ce_prev = '1;
  int rel_cyc = 0;
  int rel_bank = 0;
  bit has_rel = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (&ce_prev && !(&mem_ce_n)) begin
        chk(mem_ce_n == ~(NB'(1) << cur_addr[HW-1 -: BW]), "R2 bank enable",
            int'(mem_ce_n), int'(~(NB'(1) << cur_addr[HW-1 -: BW])));
        chk(mem_addr == cur_addr[AW-1:0], "R2 word address",
            int'(mem_addr), int'(cur_addr[AW-1:0]));
        chk(mem_oe_n == 1'b0, "R3 oe falls with ce", int'(mem_oe_n), 0);
        if (has_rel && rel_bank != int'(cur_addr[HW-1 -: BW]))
          chk(cyc - rel_cyc >= flt_c, "R6 float gap", cyc - rel_cyc, flt_c);
        rel_bank = int'(cur_addr[HW-1 -: BW]);
      end
      if (!(&ce_prev) && &mem_ce_n) begin
        rel_cyc = cyc;
        has_rel = 1;
        chk(mem_oe_n == 1'b1, "R3 oe rises with ce", int'(mem_oe_n), 1);
      end
      if (rd_done) n_done++;
      ce_prev = mem_ce_n;
    end
  end

  int prev_done = 0;
  int prev_bank = 0;
  bit has_prev = 0;

  // one read; inj raises rd_req again mid-access with another address
  task automatic do_read(input logic [HW-1:0] a, input bit inj);
    int a0, exp_s, exp_e, b, waited;
    logic [DW-1:0] got;
    b = int'(a[HW-1 -: BW]);
    cur_addr = a;
    rd_addr = a;
    rd_req = 1'b1;
    a0 = cyc + 1;
    exp_s = a0;
    if (has_prev && b != prev_bank && prev_done + flt_c > a0)
      exp_s = prev_done + flt_c;
    exp_e = exp_s + acc_c;
    @(negedge clk);
    rd_req = 1'b0;
    rd_addr = ~a;
    waited = 0;
    while (!rd_done && waited < 400) begin
      if (inj && waited == 5) begin rd_req = 1'b1; rd_addr = a ^ {BW'(1), AW'(5)}; end
      else rd_req = 1'b0;
      @(negedge clk);
      waited++;
    end
    rd_req = 1'b0;
    chk(rd_done == 1'b1 && cyc == exp_e, "R4/R6 done cycle", cyc, exp_e);
    chk(rd_data == pat(b, int'(a[AW-1:0])), "R5 read data",
        int'(rd_data), int'(pat(b, int'(a[AW-1:0]))));
    got = rd_data;
    prev_done = cyc;
    prev_bank = b;
    has_prev = 1;
    @(negedge clk);
    chk(!rd_done, "R5 done one cycle", int'(rd_done), 0);
    chk(rd_data == got, "R5 data held", int'(rd_data), int'(got));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int dn;
    logic [HW-1:0] ra;
    acc_c = ceil_cyc(E_ACC);
    flt_c = ceil_cyc(E_FLT);
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(&mem_ce_n && mem_oe_n && !rd_done, "R1 reset state", int'(mem_ce_n), NB * 0 + 15);
    rst = 1'b0;
    @(negedge clk);
    chk(&mem_ce_n && mem_oe_n && !rd_done, "R1 after reset", int'(mem_ce_n), 15);

    // directed: extremes, same bank back to back, bank change back to back
    do_read({BW'(0), AW'(0)}, 0);
    do_read({BW'(0), AW'(8191)}, 0);
    do_read({BW'(3), AW'(8191)}, 0);
    do_read({BW'(1), AW'(1234)}, 0);
    idle(20);
    do_read({BW'(2), AW'(77)}, 0);
    idle(3);
    do_read({BW'(3), AW'(4000)}, 0);

    // R7: request during an access is ignored
    dn = n_done;
    do_read({BW'(2), AW'(321)}, 1);
    idle(acc_c + flt_c + 5);
    chk(n_done == dn + 1, "R7 mid-access request ignored", n_done - dn, 1);
    chk(&mem_ce_n && mem_oe_n, "R7 no access started", int'(mem_ce_n), 15);

    // random reads with random spacing
    for (int k = 0; k < 60; k++) begin
      ra = HW'($urandom);
      if ($urandom % 3 == 0) ra[HW-1 -: BW] = BW'(prev_bank);
      idle(int'($urandom % 11));
      do_read(ra, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule